// File: doc/BRIEF.md
# AXI Read Burst Splitter

This block accepts one read transfer command at a time, given as a starting byte address, a total number of data beats and a flag that selects incrementing or fixed addressing. It breaks that transfer into a series of read-address bursts that obey the AXI length and boundary rules. It drives the read-address channel and keeps a constant transaction ID, so all data returns in the order it was requested. The block does not capture read data. It watches the read-data handshake only to know when the transfer has fully drained.

For incrementing transfers, a burst never covers more than `MAX_BEATS` beats of `DATA_BYTES` bytes. A burst also never runs past an address that is a multiple of `MAX_BEATS*DATA_BYTES`. The first burst is therefore cut short at the next such multiple, and every later burst starts exactly on one. That one alignment rule also keeps every burst inside a 4 KB page, so no separate 4 KB check is needed. Fixed-address transfers use bursts of at most 16 beats. While the slave keeps ARREADY high, a new burst is presented in every cycle.

Two counters track the bursts and the beats that have been requested but not yet returned. The number of bursts in flight is capped at `MAX_OUT`. When every burst has been issued and both counters are back at zero, the block raises a one-cycle completion pulse and accepts the next command.

Top module: `axi_rd_splitter`

## Requirements
- R1: After reset `arValid` and `done` are 0 and `cmdReady` is 1.
- R2: A command is taken only on a cycle with `cmdValid` and `cmdReady` both high. `cmdReady` is low from the cycle after acceptance until the cycle that `done` is high, and a `cmdValid` raised during that time starts no burst.
- R3: An incrementing burst is signalled with `arBurst` = 2'b01 and holds at most `MAX_BEATS` beats (default 16). It ends no later than the next multiple of `MAX_BEATS*DATA_BYTES` bytes, and each burst after the first starts on such a multiple.
- R4: A fixed burst is signalled with `arBurst` = 2'b00. It holds at most 16 beats, and every burst of the transfer carries the command address.
- R5: No incrementing burst crosses a 4096-byte address boundary.
- R6: `arLen` equals the burst's beat count minus one. The beats of all bursts add up exactly to the commanded count, and the number of bursts is the minimum that R3/R4 allow.
- R7: While `arValid` is high and `arReady` is low, `arValid`, `arAddr`, `arLen` and `arBurst` keep their values into the next cycle.
- R8: With `arReady` held high, consecutive bursts of one transfer are accepted on consecutive clock cycles.
- R9: `arId` is the constant `ID_VALUE` (default 0), `arSize` equals log2(`DATA_BYTES`) (2 by default), and `rReady` is held at 1.
- R10: The number of bursts accepted on AR whose `rLast` beat has not yet been accepted never exceeds `MAX_OUT` (default 8). Issuing pauses at that limit.
- R11: `done` is high for exactly one cycle. That cycle comes after the transfer's final `rLast` beat has been accepted and after every commanded beat has returned.
- R12: A command of zero beats issues no burst and still produces a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Transfer command present |
| cmdReady | output | 1 | Block idle, command can be taken |
| cmdAddr | input | ADDR_W | Start byte address (beat aligned) |
| cmdBeats | input | CNT_W | Total beats to read |
| cmdFixed | input | 1 | 1 = fixed address, 0 = incrementing |
| arValid | output | 1 | Read-address valid |
| arReady | input | 1 | Read-address ready |
| arId | output | ID_W | Constant transaction ID |
| arAddr | output | ADDR_W | Burst start address |
| arLen | output | 8 | Beats in burst minus one |
| arSize | output | 3 | log2 of bytes per beat |
| arBurst | output | 2 | 2'b00 fixed, 2'b01 incrementing |
| rValid | input | 1 | Read-data valid |
| rLast | input | 1 | Last beat of a burst |
| rReady | output | 1 | Read-data ready, held high |
| done | output | 1 | One-cycle transfer-complete pulse |

## Verification
The burst counter can be raised and lowered in the same cycle. This happens when a new address is accepted on the same edge that the final beat of an older burst returns. The bench provokes it by returning read data at a slow fixed cadence while ARREADY stays high, which drives the in-flight count to its cap and keeps it there. The bench judges the result in two ways. Its own model of in-flight bursts must peak at exactly `MAX_OUT` and never exceed it. The transfer must then finish with a single `done` pulse only after its model has counted every beat back.

// File: rtl/rdsplit_pkg.sv
package rdsplit_pkg;
  localparam logic [1:0] BURST_FIXED = 2'b00;
  localparam logic [1:0] BURST_INCR  = 2'b01;

  typedef struct packed {
    logic load;   // capture a new command
    logic issue;  // present the next burst on AR
  } splitStrobes_t;
endpackage

// File: rtl/rdsplit_path.sv
module rdsplit_path
  import rdsplit_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int DATA_BYTES = 4,
  parameter int MAX_BEATS  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  splitStrobes_t     stb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [CNT_W-1:0]  cmdBeats,
  input  logic              cmdFixed,
  input  logic              arReady,
  output logic              arValid,
  output logic [ADDR_W-1:0] arAddr,
  output logic [7:0]        arLen,
  output logic [1:0]        arBurst,
  output logic              remZero,
  output logic              arFire,
  output logic [8:0]        arBeats
);
  localparam int OFF_W   = $clog2(DATA_BYTES);
  localparam int MAX_LOG = $clog2(MAX_BEATS);
  localparam int FIX_MAX = (MAX_BEATS < 16) ? MAX_BEATS : 16;

  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  remaining;
  logic              fixedMode;
  logic [CNT_W-1:0]  room;
  logic [CNT_W-1:0]  cap;
  logic [CNT_W-1:0]  len;
  logic [ADDR_W-1:0] nextAddr;

  // Beats left before the next max-burst-size boundary.
  generate
    if (MAX_LOG == 0) begin : g_room_single
      assign room = CNT_W'(1);
    end else begin : g_room_aligned
      logic [MAX_LOG-1:0] beatIdx;
      assign beatIdx = curAddr[OFF_W +: MAX_LOG];
      assign room    = CNT_W'(MAX_BEATS) - CNT_W'(beatIdx);
    end
  endgenerate

  always_comb begin
    cap      = fixedMode ? CNT_W'(FIX_MAX) : room;
    len      = (remaining < cap) ? remaining : cap;
    nextAddr = fixedMode ? curAddr : curAddr + (ADDR_W'(len) << OFF_W);
  end

  assign remZero = (remaining == '0);
  assign arFire  = arValid && arReady;
  assign arBeats = 9'(arLen) + 9'd1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      remaining <= '0;
      fixedMode <= 1'b0;
      arValid   <= 1'b0;
      arAddr    <= '0;
      arLen     <= '0;
      arBurst   <= BURST_INCR;
    end else begin
      if (stb.load) begin
        curAddr   <= cmdAddr;
        remaining <= cmdBeats;
        fixedMode <= cmdFixed;
      end
      if (stb.issue) begin
        arValid   <= 1'b1;
        arAddr    <= curAddr;
        arLen     <= 8'(len - CNT_W'(1));
        arBurst   <= fixedMode ? BURST_FIXED : BURST_INCR;
        curAddr   <= nextAddr;
        remaining <= remaining - len;
      end else if (arFire) begin
        arValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rdsplit_track.sv
module rdsplit_track #(
  parameter int BURST_W = 4,
  parameter int BEAT_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               arFire,
  input  logic [8:0]         arBeats,
  input  logic               rFire,
  input  logic               rLast,
  output logic [BURST_W-1:0] burstsOut,
  output logic [BEAT_W-1:0]  beatsOut
);
  logic [BURST_W-1:0] burstsNext;
  logic [BEAT_W-1:0]  beatsNext;

  always_comb begin
    burstsNext = burstsOut;
    beatsNext  = beatsOut;
    if (arFire) begin
      burstsNext = burstsNext + BURST_W'(1);
      beatsNext  = beatsNext + BEAT_W'(arBeats);
    end
    if (rFire) begin
      beatsNext = beatsNext - BEAT_W'(1);
      if (rLast) burstsNext = burstsNext - BURST_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstsOut <= '0;
      beatsOut  <= '0;
    end else begin
      burstsOut <= burstsNext;
      beatsOut  <= beatsNext;
    end
  end
endmodule

// File: rtl/rdsplit_ctrl.sv
module rdsplit_ctrl
  import rdsplit_pkg::*;
#(
  parameter int MAX_OUT = 8,
  parameter int BURST_W = 4,
  parameter int BEAT_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic               remZero,
  input  logic               arValid,
  input  logic               arReady,
  input  logic [BURST_W-1:0] burstsOut,
  input  logic [BEAT_W-1:0]  beatsOut,
  output splitStrobes_t      stb,
  output logic               done
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t state;

  logic drained;
  logic roomForBurst;

  always_comb begin
    drained      = remZero && !arValid && (burstsOut == '0) && (beatsOut == '0);
    roomForBurst = ((BURST_W+1)'(burstsOut) + (BURST_W+1)'(arValid)) < (BURST_W+1)'(MAX_OUT);
    cmdReady     = (state == ST_IDLE);
    stb.load     = (state == ST_IDLE) && cmdValid;
    stb.issue    = (state == ST_RUN) && !remZero && (!arValid || arReady) && roomForBurst;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (cmdValid) state <= ST_RUN;
        ST_RUN: if (drained) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/axi_rd_splitter.sv
module axi_rd_splitter
  import rdsplit_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int DATA_BYTES = 4,
  parameter int MAX_BEATS  = 16,
  parameter int MAX_OUT    = 8,
  parameter int ID_W       = 4,
  parameter int ID_VALUE   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [CNT_W-1:0]  cmdBeats,
  input  logic              cmdFixed,
  output logic              arValid,
  input  logic              arReady,
  output logic [ID_W-1:0]   arId,
  output logic [ADDR_W-1:0] arAddr,
  output logic [7:0]        arLen,
  output logic [2:0]        arSize,
  output logic [1:0]        arBurst,
  input  logic              rValid,
  input  logic              rLast,
  output logic              rReady,
  output logic              done
);
  localparam int BURST_W = $clog2(MAX_OUT + 1);
  localparam int BEAT_W  = $clog2(MAX_OUT * MAX_BEATS + 1);

  splitStrobes_t      stb;
  logic               remZero;
  logic               arFire;
  logic [8:0]         arBeats;
  logic [BURST_W-1:0] burstsOut;
  logic [BEAT_W-1:0]  beatsOut;

  assign arId   = ID_W'(ID_VALUE);
  assign arSize = 3'($clog2(DATA_BYTES));
  assign rReady = 1'b1;

  rdsplit_ctrl #(.MAX_OUT(MAX_OUT), .BURST_W(BURST_W), .BEAT_W(BEAT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .remZero(remZero), .arValid(arValid), .arReady(arReady),
    .burstsOut(burstsOut), .beatsOut(beatsOut), .stb(stb), .done(done)
  );

  rdsplit_path #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_BYTES(DATA_BYTES),
                 .MAX_BEATS(MAX_BEATS)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdAddr(cmdAddr), .cmdBeats(cmdBeats),
    .cmdFixed(cmdFixed), .arReady(arReady), .arValid(arValid), .arAddr(arAddr),
    .arLen(arLen), .arBurst(arBurst), .remZero(remZero), .arFire(arFire),
    .arBeats(arBeats)
  );

  rdsplit_track #(.BURST_W(BURST_W), .BEAT_W(BEAT_W)) u_track (
    .clk(clk), .rstN(rstN), .arFire(arFire), .arBeats(arBeats),
    .rFire(rValid && rReady), .rLast(rLast),
    .burstsOut(burstsOut), .beatsOut(beatsOut)
  );
endmodule

// File: rtl/rdsplit_checker.sv
module rdsplit_checker #(
  parameter int DATA_BYTES = 4,
  parameter int MAX_BEATS  = 16,
  parameter int MAX_OUT    = 8,
  parameter int BURST_W    = 4,
  parameter int BEAT_W     = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmdReady,
  input logic               arValid,
  input logic               arReady,
  input logic [11:0]        arAddrLow,
  input logic [31:0]        arAddrFull,
  input logic [7:0]         arLen,
  input logic [1:0]         arBurst,
  input logic               done,
  input logic [BURST_W-1:0] burstsOut,
  input logic [BEAT_W-1:0]  beatsOut
);
  localparam int OFF_W = $clog2(DATA_BYTES);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    arValid && !arReady |=> arValid && $stable(arAddrFull) && $stable(arLen) && $stable(arBurst));

  assert_fixed_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    arValid && arBurst == 2'b00 |-> arLen < 8'd16);

  assert_incr_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    arValid && arBurst == 2'b01 |-> 9'(arLen) < 9'(MAX_BEATS));

  assert_no_4k_cross_R5: assert property (@(posedge clk) disable iff (!rstN)
    arValid && arBurst == 2'b01 |->
      (24'(arAddrLow) + ((24'(arLen) + 24'd1) << OFF_W)) <= 24'd4096);

  assert_bursts_cap_R10: assert property (@(posedge clk) disable iff (!rstN)
    32'(burstsOut) <= MAX_OUT);

  assert_done_clean_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> burstsOut == '0 && beatsOut == '0 && !arValid);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !arValid && burstsOut == '0);
endmodule

bind axi_rd_splitter rdsplit_checker #(
  .DATA_BYTES(DATA_BYTES), .MAX_BEATS(MAX_BEATS), .MAX_OUT(MAX_OUT),
  .BURST_W(BURST_W), .BEAT_W(BEAT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .arValid(arValid),
  .arReady(arReady), .arAddrLow(arAddr[11:0]), .arAddrFull(32'(arAddr)),
  .arLen(arLen), .arBurst(arBurst), .done(done),
  .burstsOut(burstsOut), .beatsOut(beatsOut)
);

// File: tb/axi_rd_splitter_bench.sv
`timescale 1ns/1ps
module axi_rd_splitter_bench;
  localparam int MAXB = 16;
  localparam int BYTES = 4;
  localparam int MAXO = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [31:0] cmdAddr = '0;
  logic [15:0] cmdBeats = '0;
  logic cmdFixed = 1'b0;
  logic arValid;
  logic arReady = 1'b0;
  logic [3:0] arId;
  logic [31:0] arAddr;
  logic [7:0] arLen;
  logic [2:0] arSize;
  logic [1:0] arBurst;
  logic rValid = 1'b0;
  logic rLast = 1'b0;
  logic rReady;
  logic done;

  always #4 clk = ~clk;

  axi_rd_splitter u_axi_rd_splitter (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdBeats(cmdBeats), .cmdFixed(cmdFixed),
    .arValid(arValid), .arReady(arReady), .arId(arId), .arAddr(arAddr),
    .arLen(arLen), .arSize(arSize), .arBurst(arBurst), .rValid(rValid),
    .rLast(rLast), .rReady(rReady), .done(done)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic wdFired = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic arRand = 1'b0, rRand = 1'b0, rSlow = 1'b0;

  int recAddr [64];
  int recLen [64];
  logic [1:0] recBurst [64];
  int recCyc [64];
  int nRec = 0;
  int qLen [64];
  int wrP = 0, rdP = 0, beatCnt = 0, rBeats = 0, maxOut = 0;
  int doneCnt = 0, donePulseErr = 0;
  logic prevDone = 1'b0, prevStall = 1'b0, rGo;
  logic [31:0] sAddr;
  logic [7:0] sLen;
  logic [1:0] sBurst;
  int stallErr = 0, stallSeen = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Slave model: decisions made at the falling edge take effect at the next rising edge.
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (cyc > 150000) wdFired = 1'b1;
    if (!rstN) begin
      arReady = 1'b0; rValid = 1'b0; rLast = 1'b0;
    end else begin
      if (prevStall) begin  // R7 hold check
        stallSeen++;
        if (!(arValid && arAddr == sAddr && arLen == sLen && arBurst == sBurst)) stallErr++;
      end
      if (done) begin
        doneCnt++;
        if (prevDone) donePulseErr++;
      end
      prevDone = done;
      rGo = rSlow ? (cyc % 8 == 0) : (rRand ? lfsr[3] : 1'b1);
      if (wrP != rdP && rGo) begin
        rValid = 1'b1;
        rLast = (beatCnt == qLen[rdP % 64] - 1);
        rBeats++;
        if (rLast) begin rdP++; beatCnt = 0; end else beatCnt++;
      end else begin
        rValid = 1'b0; rLast = 1'b0;
      end
      arReady = arRand ? lfsr[0] : 1'b1;
      if (arValid && arReady && nRec < 64) begin
        recAddr[nRec] = int'(arAddr);
        recLen[nRec] = int'(arLen);
        recBurst[nRec] = arBurst;
        recCyc[nRec] = cyc;
        nRec++;
        qLen[wrP % 64] = int'(arLen) + 1;
        wrP++;
      end
      prevStall = arValid && !arReady;
      sAddr = arAddr; sLen = arLen; sBurst = arBurst;
      if (wrP - rdP > maxOut) maxOut = wrP - rdP;
    end
  end

  task automatic runCmd(input int addr, input int beats, input logic fixed,
                        input logic aR, input logic rR, input logic rS,
                        input logic poke, input int expBursts);
    int a, rem, k, len, room, d0;
    arRand = aR; rRand = rR; rSlow = rS;
    @(negedge clk);
    nRec = 0; rBeats = 0; maxOut = 0; d0 = doneCnt;
    while (!cmdReady && !wdFired) @(negedge clk);
    cmdValid = 1'b1; cmdAddr = 32'(addr); cmdBeats = 16'(beats); cmdFixed = fixed;
    @(negedge clk);
    cmdValid = 1'b0;
    if (poke) begin
      // R2: a command offered while busy must be refused and start nothing
      cmdValid = 1'b1; cmdAddr = 32'h0000_0800; cmdBeats = 16'd5; cmdFixed = 1'b0;
      for (int i = 0; i < 3; i++) begin
        chk(!cmdReady, "R2 busy cmdReady", int'(cmdReady), 0);
        @(negedge clk);
      end
      cmdValid = 1'b0;
    end
    while (doneCnt == d0 && !wdFired) @(negedge clk);
    // Expected burst split computed from R3/R4
    a = addr; rem = beats; k = 0;
    while (rem > 0) begin
      if (fixed) len = (rem < 16) ? rem : 16;
      else begin
        room = MAXB - ((a / BYTES) % MAXB);
        len = (rem < room) ? rem : room;
      end
      if (k < nRec) begin
        chk(recAddr[k] == a, fixed ? "R4 addr" : "R3 addr", recAddr[k], a);
        chk(recLen[k] == len - 1, "R6 arLen", recLen[k], len - 1);
        chk(recBurst[k] == (fixed ? 2'b00 : 2'b01), "R4 arBurst", int'(recBurst[k]),
            fixed ? 0 : 1);
        if (!fixed)
          chk((recAddr[k] % 4096) + (recLen[k] + 1) * BYTES <= 4096, "R5 4k",
              (recAddr[k] % 4096) + (recLen[k] + 1) * BYTES, 4096);
      end
      if (!fixed) a = a + len * BYTES;
      rem -= len; k++;
    end
    chk(nRec == k, "R6 burst count", nRec, k);
    chk(nRec == expBursts, "R6 table count", nRec, expBursts);
    chk(rBeats == beats && wrP == rdP, "R11 drained at done", rBeats, beats);
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] beats;
    logic        fixed;
    logic [7:0]  nb;
    logic        aR;
    logic        rR;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0000_0000, 16'd40, 1'b0, 8'd3, 1'b0, 1'b0},
    '{32'h0000_0024, 16'd30, 1'b0, 8'd3, 1'b1, 1'b0},
    '{32'h0000_0FF8, 16'd20, 1'b0, 8'd3, 1'b0, 1'b1},
    '{32'h0000_0100, 16'd40, 1'b1, 8'd3, 1'b1, 1'b1},
    '{32'h0000_0030, 16'd3,  1'b0, 8'd1, 1'b1, 1'b0},
    '{32'h0000_003C, 16'd1,  1'b0, 8'd1, 1'b0, 1'b0},
    '{32'h0000_0200, 16'd5,  1'b1, 8'd1, 1'b0, 1'b1},
    '{32'h0000_1FC4, 16'd15, 1'b0, 8'd1, 1'b1, 1'b1}
  };

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!arValid, "R1 arValid", int'(arValid), 0);
    chk(!done, "R1 done", int'(done), 0);
    chk(cmdReady, "R1 cmdReady", int'(cmdReady), 1);
    // R9 constant fields
    chk(arId == 4'd0, "R9 arId", int'(arId), 0);
    chk(arSize == 3'd2, "R9 arSize", int'(arSize), 2);
    chk(rReady, "R9 rReady", int'(rReady), 1);

    // Table walk: R3 R4 R5 R6 R11, first vector also pokes a busy command (R2)
    for (int v = 0; v < 8; v++)
      runCmd(int'(VECS[v].addr), int'(VECS[v].beats), VECS[v].fixed, VECS[v].aR,
             VECS[v].rR, 1'b0, v == 0, int'(VECS[v].nb));

    // R8: back-to-back issue with ARREADY always high
    runCmd(32'h400, 48, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3);
    for (int k = 1; k < 3; k++)
      chk(recCyc[k] == recCyc[k-1] + 1, "R8 consecutive", recCyc[k] - recCyc[k-1], 1);

    // R10: slow data return drives in-flight bursts to the cap
    runCmd(32'h0, 200, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 13);
    chk(maxOut == MAXO, "R10 in-flight peak", maxOut, MAXO);

    // R12: zero-beat command
    runCmd(32'h40, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    chk(cmdReady, "R12 ready after empty", int'(cmdReady), 1);

    chk(stallSeen > 0 && stallErr == 0, "R7 hold under stall", stallErr, 0);
    chk(donePulseErr == 0, "R11 single-cycle done", donePulseErr, 0);
    chk(doneCnt == 11, "R11 done count", doneCnt, 11);
    chk(arId == 4'd0 && arSize == 3'd2 && rReady, "R9 constants after run", int'(arSize), 2);

    if (wdFired) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule